// File: doc/BRIEF.md
# Paged Non-Volatile Store Program/Erase Sequencer

This block accepts read, program and erase commands from a host that drives a command strobe, a 3-bit operation code, a byte address and up to four 32-bit data words. It sequences each command into a paged storage array. The array is held inside the block as a parameterised bank of 32-bit registers, so the block runs on its own in simulation. Single-word program, four-word burst program, single-page erase and whole-array erase take modelled latencies that are set by parameters. A read finishes in one cycle.

Every page has its own write-protect input bit. A protected page refuses program and erase. A whole-array erase is refused while any page is protected. A separate read-protect input blocks reads. Storage behaves like flash: an erased word reads all ones, and programming can only clear bits. The block reports a busy level, a one-cycle done pulse and four sticky error flags that the host clears. The full-size device is 128 pages of 2 kB. The defaults are smaller so that elaboration stays light, and the sizing parameters scale up to the full size.

The controller has four states. IDLE waits for a command and starts it if it is accepted. PROG counts the program latency once for each word. ERASE counts the erase latency. FINISH raises done for one cycle. The transitions are:
- IDLE goes to FINISH on an accepted read.
- IDLE goes to PROG on an accepted single or burst program.
- IDLE goes to ERASE on an accepted page or array erase.
- PROG stays in PROG after each non-final word is written.
- PROG goes to FINISH after the final word is written.
- ERASE goes to FINISH when the erase is applied.
- FINISH always returns to IDLE.

A rejected command never leaves IDLE.

Top module: `flash_ctl`

## Requirements
- R1: After reset, busy, done and all error flags are 0 and every stored word reads 32'hFFFFFFFF.
- R2: A read (op 0) issued while idle and not read-protected is busy for exactly 1 cycle. It returns the word at byte address bits [AW-1:2] on rdata, and rdata holds that value afterwards.
- R3: A single-word program (op 1, data in cmd_wdata[31:0]) is busy for PROG_CYCLES+1 cycles. It stores the old word ANDed with the new data.
- R4: A burst program (op 2) writes cmd_wdata word k (bits [32k+31:32k]) to address base+4k for k = 0..3. It is busy for 4*PROG_CYCLES+1 cycles.
- R5: A burst program whose address bits [3:0] are not zero is rejected: busy stays 0, no word changes, and error bit 1 is set.
- R6: A page erase (op 3) sets every word of the addressed page (page = address bits [AW-1:log2 PAGE_BYTES]) to all ones and leaves the other pages unchanged. It is busy for ERASE_CYCLES+1 cycles.
- R7: An array erase (op 4) sets every word to all ones and is busy for ERASE_CYCLES+1 cycles. If any wp_mask bit is 1, it is rejected: busy stays 0, nothing changes, and error bit 0 is set.
- R8: A program or page erase aimed at a page whose wp_mask bit is 1 is rejected: busy stays 0, the array is unchanged, and error bit 0 is set.
- R9: A read issued while rd_protect is 1 is rejected: busy stays 0, rdata becomes 0, and error bit 3 is set.
- R10: A command strobed while busy is ignored. The running operation completes unchanged, and error bit 2 is set.
- R11: Error flags are sticky. Each stays 1 until err_clr is sampled high, and err_clr clears all four flags.
- R12: An accepted command raises done for exactly one cycle, and that cycle is the last cycle in which busy is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command strobe, sampled once per cycle |
| cmd_op | input | 3 | 0 read, 1 single program, 2 burst program, 3 page erase, 4 array erase, 5-7 ignored |
| cmd_addr | input | AW | Byte address into the array |
| cmd_wdata | input | 128 | Program data, word k in bits [32k+31:32k] |
| wp_mask | input | NUM_PAGES | Write-protect bit for each page |
| rd_protect | input | 1 | Blocks reads when 1 |
| err_clr | input | 1 | Clears all sticky error flags |
| busy | output | 1 | High from command acceptance until completion |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 32 | Last read result |
| err | output | 4 | Sticky flags: bit0 protect, bit1 alignment, bit2 busy collision, bit3 read protect |

## Verification
Take the edge that samples the command strobe as edge 0. Busy is then first seen in the cycle after edge 0 and stays high for 1 cycle on a read, PROG_CYCLES+1 cycles on a single program, 4*PROG_CYCLES+1 cycles on a burst, and ERASE_CYCLES+1 cycles on an erase. Done must appear only in the last of those cycles. Error flags and the rdata of a rejected read appear in the cycle after edge 0. The bench drives and samples on falling edges, counts the busy cycles and the position of done for each command, and compares them with these figures. It checks stored contents by later reads through the same port.

// File: rtl/flash_ctl_pkg.sv
package flash_ctl_pkg;

    typedef enum logic [2:0] {
        OP_READ      = 3'd0,
        OP_PROG1     = 3'd1,
        OP_PROG4     = 3'd2,
        OP_ERASE_PG  = 3'd3,
        OP_ERASE_ALL = 3'd4
    } op_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_PROG,
        ST_ERASE,
        ST_FINISH
    } state_e;

    localparam int ERR_WP    = 0;
    localparam int ERR_ALIGN = 1;
    localparam int ERR_BUSY  = 2;
    localparam int ERR_RDP   = 3;
    localparam int ERR_W     = 4;

endpackage

// File: rtl/flash_ctl_delay.sv
// Down-counter that models program and erase durations.
module flash_ctl_delay #(
    parameter int TW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [TW-1:0] load_val,
    output logic          expired
);

    logic [TW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q == '0);

endmodule

// File: rtl/flash_ctl_guard.sv
// Decides whether an incoming command may start.
module flash_ctl_guard
    import flash_ctl_pkg::*;
#(
    parameter int NUM_PAGES  = 8,
    parameter int PAGE_BYTES = 64
) (
    input  logic [2:0]                                   op,
    input  logic [$clog2(NUM_PAGES*PAGE_BYTES)-1:0]      addr,
    input  logic [NUM_PAGES-1:0]                         wp_mask,
    input  logic                                         rd_protect,
    output logic                                         known,
    output logic                                         viol_wp,
    output logic                                         viol_align,
    output logic                                         viol_rdp
);

    localparam int AW       = $clog2(NUM_PAGES*PAGE_BYTES);
    localparam int PG_SHIFT = $clog2(PAGE_BYTES);
    localparam int PW       = $clog2(NUM_PAGES);

    logic [PW-1:0] page;
    logic          page_locked;
    logic          targets_page;

    assign page        = addr[AW-1:PG_SHIFT];
    assign page_locked = wp_mask[page];

    always_comb begin
        known        = 1'b0;
        targets_page = 1'b0;
        unique case (op)
            OP_READ:      known = 1'b1;
            OP_PROG1,
            OP_PROG4,
            OP_ERASE_PG: begin
                known        = 1'b1;
                targets_page = 1'b1;
            end
            OP_ERASE_ALL: known = 1'b1;
            default:      known = 1'b0;
        endcase
    end

    assign viol_wp    = (targets_page && page_locked) ||
                        ((op == OP_ERASE_ALL) && (|wp_mask));
    assign viol_align = (op == OP_PROG4) && (addr[3:0] != 4'd0);
    assign viol_rdp   = (op == OP_READ) && rd_protect;

endmodule

// File: rtl/flash_ctl_store.sv
// Word array with flash semantics: erase sets ones, program ANDs.
module flash_ctl_store #(
    parameter int NUM_PAGES      = 8,
    parameter int WORDS_PER_PAGE = 16
) (
    input  logic                                            clk,
    input  logic                                            rst_n,
    input  logic [$clog2(NUM_PAGES*WORDS_PER_PAGE)-1:0]     rd_idx,
    output logic [31:0]                                     rd_data,
    input  logic                                            wr_en,
    input  logic [$clog2(NUM_PAGES*WORDS_PER_PAGE)-1:0]     wr_idx,
    input  logic [31:0]                                     wr_data,
    input  logic                                            erase_pg,
    input  logic [$clog2(NUM_PAGES)-1:0]                    erase_page,
    input  logic                                            erase_all
);

    localparam int WORDS = NUM_PAGES * WORDS_PER_PAGE;
    localparam int WIW   = $clog2(WORDS);
    localparam int PW    = $clog2(NUM_PAGES);

    logic [31:0] rd_bus [WORDS];

    for (genvar w = 0; w < WORDS; w++) begin : g_word
        localparam int PAGE_OF = w / WORDS_PER_PAGE;
        logic [31:0] cell_q;
        logic        hit_erase;
        logic        hit_write;

        assign hit_erase = erase_all ||
                           (erase_pg && (erase_page == PW'(PAGE_OF)));
        assign hit_write = wr_en && (wr_idx == WIW'(w));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                cell_q <= '1;
            end else if (hit_erase) begin
                cell_q <= '1;
            end else if (hit_write) begin
                cell_q <= cell_q & wr_data;
            end
        end

        assign rd_bus[w] = cell_q;
    end

    assign rd_data = rd_bus[rd_idx];

endmodule

// File: rtl/flash_ctl.sv
module flash_ctl
    import flash_ctl_pkg::*;
#(
    parameter int NUM_PAGES    = 8,
    parameter int PAGE_BYTES   = 64,
    parameter int PROG_CYCLES  = 4,
    parameter int ERASE_CYCLES = 20
) (
    input  logic                                         clk,
    input  logic                                         rst_n,
    input  logic                                         cmd_valid,
    input  logic [2:0]                                   cmd_op,
    input  logic [$clog2(NUM_PAGES*PAGE_BYTES)-1:0]      cmd_addr,
    input  logic [127:0]                                 cmd_wdata,
    input  logic [NUM_PAGES-1:0]                         wp_mask,
    input  logic                                         rd_protect,
    input  logic                                         err_clr,
    output logic                                         busy,
    output logic                                         done,
    output logic [31:0]                                  rdata,
    output logic [3:0]                                   err
);

    localparam int AW             = $clog2(NUM_PAGES*PAGE_BYTES);
    localparam int WORDS_PER_PAGE = PAGE_BYTES / 4;
    localparam int WIW            = $clog2(NUM_PAGES*WORDS_PER_PAGE);
    localparam int PW             = $clog2(NUM_PAGES);
    localparam int MAXLAT         = (PROG_CYCLES > ERASE_CYCLES) ? PROG_CYCLES : ERASE_CYCLES;
    localparam int TW             = $clog2(MAXLAT + 1);
    localparam logic [TW-1:0] PROG_LOAD  = TW'(PROG_CYCLES - 1);
    localparam logic [TW-1:0] ERASE_LOAD = TW'(ERASE_CYCLES - 1);

    state_e          state_q, state_d;
    op_e             op_q;
    logic [WIW-1:0]  word_q;
    logic [1:0]      beat_q;
    logic [127:0]    data_q;
    logic [3:0]      err_q;
    logic [31:0]     rdata_q;

    logic            known, viol_wp, viol_align, viol_rdp;
    logic            take;
    logic            last_beat;
    logic            expired;
    logic            tmr_load;
    logic [TW-1:0]   tmr_val;
    logic            wr_en;
    logic [WIW-1:0]  wr_idx;
    logic [31:0]     wr_data;
    logic            erase_pg_go;
    logic            erase_all_go;
    logic [31:0]     rd_word;
    logic [3:0]      err_set;

    flash_ctl_guard #(
        .NUM_PAGES  (NUM_PAGES),
        .PAGE_BYTES (PAGE_BYTES)
    ) u_guard (
        .op         (cmd_op),
        .addr       (cmd_addr),
        .wp_mask    (wp_mask),
        .rd_protect (rd_protect),
        .known      (known),
        .viol_wp    (viol_wp),
        .viol_align (viol_align),
        .viol_rdp   (viol_rdp)
    );

    flash_ctl_delay #(
        .TW (TW)
    ) u_delay (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (expired)
    );

    flash_ctl_store #(
        .NUM_PAGES      (NUM_PAGES),
        .WORDS_PER_PAGE (WORDS_PER_PAGE)
    ) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd_idx     (cmd_addr[AW-1:2]),
        .rd_data    (rd_word),
        .wr_en      (wr_en),
        .wr_idx     (wr_idx),
        .wr_data    (wr_data),
        .erase_pg   (erase_pg_go),
        .erase_page (word_q[WIW-1 -: PW]),
        .erase_all  (erase_all_go)
    );

    assign take      = (state_q == ST_IDLE) && cmd_valid && known &&
                       !viol_wp && !viol_align && !viol_rdp;
    assign last_beat = (op_q == OP_PROG4) ? (beat_q == 2'd3) : (beat_q == 2'd0);
    assign wr_idx    = (op_q == OP_PROG4) ? {word_q[WIW-1:2], beat_q} : word_q;
    assign wr_data   = data_q[beat_q*32 +: 32];

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (take) begin
                    unique case (cmd_op)
                        OP_READ:               state_d = ST_FINISH;
                        OP_PROG1, OP_PROG4:    state_d = ST_PROG;
                        default:               state_d = ST_ERASE;
                    endcase
                end
            end
            ST_PROG: begin
                if (expired && last_beat) begin
                    state_d = ST_FINISH;
                end
            end
            ST_ERASE: begin
                if (expired) begin
                    state_d = ST_FINISH;
                end
            end
            ST_FINISH: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // Outputs and datapath controls
    always_comb begin
        busy         = (state_q != ST_IDLE);
        done         = (state_q == ST_FINISH);
        wr_en        = (state_q == ST_PROG) && expired;
        erase_pg_go  = (state_q == ST_ERASE) && expired && (op_q == OP_ERASE_PG);
        erase_all_go = (state_q == ST_ERASE) && expired && (op_q == OP_ERASE_ALL);
        tmr_load     = 1'b0;
        tmr_val      = PROG_LOAD;
        if (take && ((cmd_op == OP_PROG1) || (cmd_op == OP_PROG4))) begin
            tmr_load = 1'b1;
            tmr_val  = PROG_LOAD;
        end else if (take && (cmd_op != OP_READ)) begin
            tmr_load = 1'b1;
            tmr_val  = ERASE_LOAD;
        end else if (wr_en && !last_beat) begin
            tmr_load = 1'b1;
            tmr_val  = PROG_LOAD;
        end
        err_set            = '0;
        err_set[ERR_BUSY]  = busy && cmd_valid;
        err_set[ERR_WP]    = !busy && cmd_valid && viol_wp;
        err_set[ERR_ALIGN] = !busy && cmd_valid && viol_align;
        err_set[ERR_RDP]   = !busy && cmd_valid && viol_rdp;
    end

    // Command capture, read data and sticky flags
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_q    <= OP_READ;
            word_q  <= '0;
            beat_q  <= '0;
            data_q  <= '0;
            rdata_q <= '0;
            err_q   <= '0;
        end else begin
            err_q <= (err_q & {ERR_W{~err_clr}}) | err_set;
            if (take) begin
                op_q   <= op_e'(cmd_op);
                word_q <= cmd_addr[AW-1:2];
                data_q <= cmd_wdata;
                beat_q <= '0;
                if (cmd_op == OP_READ) begin
                    rdata_q <= rd_word;
                end
            end else if (err_set[ERR_RDP]) begin
                rdata_q <= '0;
            end else if (wr_en) begin
                beat_q <= beat_q + 2'd1;
            end
        end
    end

    assign rdata = rdata_q;
    assign err   = err_q;

endmodule

// File: rtl/flash_ctl_chk.sv
module flash_ctl_chk #(
    parameter int NUM_PAGES  = 8,
    parameter int PAGE_BYTES = 64
) (
    input logic                                      clk,
    input logic                                      rst_n,
    input logic                                      cmd_valid,
    input logic [2:0]                                cmd_op,
    input logic [$clog2(NUM_PAGES*PAGE_BYTES)-1:0]   cmd_addr,
    input logic [NUM_PAGES-1:0]                      wp_mask,
    input logic                                      rd_protect,
    input logic                                      err_clr,
    input logic                                      busy,
    input logic                                      done,
    input logic [31:0]                               rdata,
    input logic [3:0]                                err
);

    localparam int AW       = $clog2(NUM_PAGES*PAGE_BYTES);
    localparam int PG_SHIFT = $clog2(PAGE_BYTES);

    logic idle_cmd;
    logic page_locked;
    assign idle_cmd    = !busy && cmd_valid;
    assign page_locked = wp_mask[cmd_addr[AW-1:PG_SHIFT]];

    AST_DONE_IN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> busy);  // R12

    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);  // R12

    AST_COLLIDE_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cmd_valid) |=> err[2]);  // R10

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        ((|err) && !err_clr) |=> ((err & $past(err)) == $past(err)));  // R11

    AST_WP_REFUSE: assert property (@(posedge clk) disable iff (!rst_n)
        (idle_cmd && (cmd_op >= 3'd1) && (cmd_op <= 3'd3) && page_locked)
        |=> (!busy && err[0]));  // R8

    AST_MASS_REFUSE: assert property (@(posedge clk) disable iff (!rst_n)
        (idle_cmd && (cmd_op == 3'd4) && (|wp_mask)) |=> (!busy && err[0]));  // R7

    AST_ALIGN_REFUSE: assert property (@(posedge clk) disable iff (!rst_n)
        (idle_cmd && (cmd_op == 3'd2) && (cmd_addr[3:0] != 4'd0))
        |=> (!busy && err[1]));  // R5

    AST_RDP_REFUSE: assert property (@(posedge clk) disable iff (!rst_n)
        (idle_cmd && (cmd_op == 3'd0) && rd_protect)
        |=> (!busy && err[3] && (rdata == 32'd0)));  // R9

endmodule

bind flash_ctl flash_ctl_chk #(
    .NUM_PAGES  (NUM_PAGES),
    .PAGE_BYTES (PAGE_BYTES)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_valid  (cmd_valid),
    .cmd_op     (cmd_op),
    .cmd_addr   (cmd_addr),
    .wp_mask    (wp_mask),
    .rd_protect (rd_protect),
    .err_clr    (err_clr),
    .busy       (busy),
    .done       (done),
    .rdata      (rdata),
    .err        (err)
);

// File: tb/flash_ctl_tb.sv
module flash_ctl_tb;

    localparam int NP    = 8;
    localparam int PB    = 64;
    localparam int PROG  = 3;
    localparam int ERASE = 5;
    localparam int AW    = $clog2(NP*PB);

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            cmd_valid = 1'b0;
    logic [2:0]      cmd_op = 3'd0;
    logic [AW-1:0]   cmd_addr = '0;
    logic [127:0]    cmd_wdata = '0;
    logic [NP-1:0]   wp_mask = '0;
    logic            rd_protect = 1'b0;
    logic            err_clr = 1'b0;
    logic            busy, done;
    logic [31:0]     rdata;
    logic [3:0]      err;

    int total = 0;
    int bad   = 0;

    always #10 clk = ~clk;

    flash_ctl #(
        .NUM_PAGES    (NP),
        .PAGE_BYTES   (PB),
        .PROG_CYCLES  (PROG),
        .ERASE_CYCLES (ERASE)
    ) u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_valid  (cmd_valid),
        .cmd_op     (cmd_op),
        .cmd_addr   (cmd_addr),
        .cmd_wdata  (cmd_wdata),
        .wp_mask    (wp_mask),
        .rd_protect (rd_protect),
        .err_clr    (err_clr),
        .busy       (busy),
        .done       (done),
        .rdata      (rdata),
        .err        (err)
    );

    task automatic check_eq(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Issue one command, then count busy cycles and where done appeared.
    task automatic exec(input logic [2:0] op, input logic [AW-1:0] addr,
                        input logic [127:0] data, input int exp_cyc, input string tag);
        int cyc = 0;
        int dcnt = 0;
        int dlast = 0;
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op; cmd_addr = addr; cmd_wdata = data;
        @(negedge clk);
        cmd_valid = 1'b0;
        while (busy && cyc < 1000) begin
            cyc++;
            if (done) begin dcnt++; dlast = cyc; end
            @(negedge clk);
        end
        check_eq({tag, " busy cycles"}, cyc, exp_cyc);
        if (exp_cyc > 0)
            check_eq({tag, " R12 done once at end"}, {30'd0, (dcnt == 1), (dlast == cyc)}, 32'd3);
        else
            check_eq({tag, " no done"}, dcnt, 0);
    endtask

    task automatic rd(input logic [AW-1:0] addr, input logic [31:0] exp, input string tag);
        exec(3'd0, addr, '0, 1, {tag, " R2 read"});
        check_eq({tag, " R2 rdata"}, rdata, exp);
    endtask

    task automatic clear_err();
        @(negedge clk); err_clr = 1'b1;
        @(negedge clk); err_clr = 1'b0;
    endtask

    task automatic t_reset();
        check_eq("R1 busy", {31'd0, busy}, 0);
        check_eq("R1 done", {31'd0, done}, 0);
        check_eq("R1 err", {28'd0, err}, 0);
        rd(9'h000, 32'hFFFF_FFFF, "R1 first word");
        rd(9'h1FC, 32'hFFFF_FFFF, "R1 last word");
    endtask

    task automatic t_single();
        exec(3'd1, 9'h008, {96'd0, 32'h1234_5678}, PROG+1, "R3 prog");
        rd(9'h008, 32'h1234_5678, "R3 first value");
        exec(3'd1, 9'h008, {96'd0, 32'hFF00_FF00}, PROG+1, "R3 reprog");
        rd(9'h008, 32'h1200_5600, "R3 AND result");
    endtask

    task automatic t_burst();
        exec(3'd2, 9'h010, {32'hDDDD_0003, 32'hCCCC_0002, 32'hBBBB_0001, 32'hAAAA_0000},
             4*PROG+1, "R4 burst");
        rd(9'h010, 32'hAAAA_0000, "R4 word0");
        rd(9'h014, 32'hBBBB_0001, "R4 word1");
        rd(9'h018, 32'hCCCC_0002, "R4 word2");
        rd(9'h01C, 32'hDDDD_0003, "R4 word3");
    endtask

    task automatic t_misalign();
        exec(3'd2, 9'h014, '0, 0, "R5 misaligned");
        check_eq("R5 err", {28'd0, err}, 32'h2);
        rd(9'h014, 32'hBBBB_0001, "R5 unchanged");
        clear_err();
    endtask

    task automatic t_protect();
        wp_mask = 8'b0000_0010;
        exec(3'd1, 9'h040, '0, 0, "R8 prog locked");
        check_eq("R8 err", {28'd0, err}, 32'h1);
        rd(9'h040, 32'hFFFF_FFFF, "R8 unchanged");
        clear_err();
        exec(3'd3, 9'h040, '0, 0, "R8 erase locked");
        check_eq("R8 erase err", {28'd0, err}, 32'h1);
        clear_err();
        exec(3'd4, 9'h000, '0, 0, "R7 mass locked");
        check_eq("R7 err", {28'd0, err}, 32'h1);
        rd(9'h008, 32'h1200_5600, "R7 unchanged");
        clear_err();
        wp_mask = '0;
    endtask

    task automatic t_erase();
        exec(3'd1, 9'h044, {96'd0, 32'hA5A5_A5A5}, PROG+1, "R6 prep");
        exec(3'd3, 9'h020, '0, ERASE+1, "R6 page erase");
        rd(9'h008, 32'hFFFF_FFFF, "R6 page0 erased");
        rd(9'h01C, 32'hFFFF_FFFF, "R6 page0 erased hi");
        rd(9'h044, 32'hA5A5_A5A5, "R6 page1 kept");
        exec(3'd4, 9'h000, '0, ERASE+1, "R7 mass erase");
        rd(9'h044, 32'hFFFF_FFFF, "R7 erased");
        check_eq("R7 no err", {28'd0, err}, 0);
    endtask

    task automatic t_collide();
        int cyc = 0;
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = 3'd3; cmd_addr = 9'h080;
        @(negedge clk);
        cmd_op = 3'd1; cmd_addr = 9'h008; cmd_wdata = {96'd0, 32'h0};
        @(negedge clk);
        cmd_valid = 1'b0;
        cyc = 2;
        while (busy && cyc < 1000) begin cyc++; @(negedge clk); end
        check_eq("R10 erase length kept", cyc, ERASE+1 + 1);
        check_eq("R10 err", {28'd0, err}, 32'h4);
        rd(9'h008, 32'hFFFF_FFFF, "R10 program ignored");
    endtask

    task automatic t_sticky();
        repeat (4) @(negedge clk);
        check_eq("R11 held", {28'd0, err}, 32'h4);
        clear_err();
        check_eq("R11 cleared", {28'd0, err}, 0);
    endtask

    task automatic t_rdp();
        exec(3'd1, 9'h00C, {96'd0, 32'h0BAD_F00D}, PROG+1, "R9 prep");
        rd(9'h00C, 32'h0BAD_F00D, "R9 before");
        rd_protect = 1'b1;
        exec(3'd0, 9'h00C, '0, 0, "R9 blocked read");
        check_eq("R9 rdata", rdata, 32'd0);
        check_eq("R9 err", {28'd0, err}, 32'h8);
        rd_protect = 1'b0;
        clear_err();
        rd(9'h00C, 32'h0BAD_F00D, "R9 after");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_single();
        t_burst();
        t_misalign();
        t_protect();
        t_erase();
        t_collide();
        t_sticky();
        t_rdp();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule